// File: doc/BRIEF.md
# Processor wake-up interrupt sequencer

This block sends inter-processor interrupt commands by writing a two-word command register: a high word that carries the destination and a low word that carries the vector, delivery mode, level and destination shorthand. The write of the low word launches the interrupt. After each launch the block reads the low word back repeatedly, and it moves on only when the delivery-busy bit reads zero.

A request carries a command kind, a target ID, a broadcast flag, a vector and a start address. Three kinds send one command each: fixed, SMI and INIT. The fourth kind runs the full wake-up chain. That chain is an INIT command, a 10 µs pause, a STARTUP command, a 200 µs pause and then a second STARTUP command that is the same as the first. The STARTUP vector is the page number of the start address. The address must sit on a 4 KiB boundary below 1 MiB. Otherwise the request is refused with an error and nothing is sent. Pauses are counted in clock cycles through `CLK_PER_US`.

Top module: `ipi_seq`

## Requirements
- R1: The high word carries the target ID in bits 31:24 and zero elsewhere. In broadcast mode the high word is all zero.
- R2: Each command is two writes on consecutive cycles: the high word (`cmd_hi`=1) first, then the low word (`cmd_hi`=0).
- R3: After each low-word write the block reads the status every cycle (`poll_rd`). It issues nothing further until `poll_data` bit 12 reads 0. All other bits of the read value are ignored.
- R4: The low word holds the vector in [7:0], the delivery mode in [10:8] and level = 1 in bit 14. The shorthand in [19:18] is 3 ("all excluding self") when broadcast and 0 otherwise. All other bits are zero.
- R5: `kind` 0 sends a fixed command (mode 0, vector from `vec`). `kind` 1 sends SMI (mode 2, vector 0). `kind` 2 sends INIT (mode 5, vector 0).
- R6: `kind` 3 sends INIT (mode 5, vector 0) and then two STARTUP commands (mode 6) whose vector is `start_addr[19:12]`.
- R7: Counted from the cycle after the poll that sees delivery clear, the next high-word write follows 10·CLK_PER_US cycles after INIT and 200·CLK_PER_US cycles after the first STARTUP.
- R8: A `kind` 3 request with `start_addr` ≥ 0x100000 or with nonzero bits 11:0 raises `err` and sends nothing. `err` stays high until the next accepted request.
- R9: A request that arrives while `busy` is high is ignored.
- R10: `busy` is high from the cycle after acceptance until the sequence ends. `done` then pulses for exactly one cycle, with `busy` already low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Start request |
| kind | input | 2 | 0 fixed, 1 SMI, 2 INIT, 3 wake-up chain |
| target | input | 8 | Destination ID |
| bcast | input | 1 | Send to all processors except self |
| vec | input | 8 | Vector for fixed commands |
| start_addr | input | 32 | Start address for the wake-up chain |
| poll_data | input | 32 | Low-word read value; bit 12 is delivery busy |
| cmd_wr | output | 1 | Command register write strobe |
| cmd_hi | output | 1 | 1 = high word, 0 = low word |
| cmd_data | output | 32 | Write data |
| poll_rd | output | 1 | Status read strobe |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Rejected start address |

## Verification
The fixed command is swept over all 256 vectors, with the broadcast flag, the target and the acceptor's busy length all varying. This separates vector packing from shorthand and destination packing. SMI and INIT are swept over targets in both destination styles to check their mode codes. The wake-up chain runs on pages spread from 0 to 255 with acceptor delays of 0 to 3 polls. Exact spacing between low-word writes tells a wrong gap length apart from a miscounted poll. Bad addresses at the 1 MiB edge and off page boundaries, followed by good requests and by a request issued mid-sequence, exercise refusal, error clearing and request ignoring.

// File: rtl/ipi_seq.sv
module ipi_seq #(
  parameter int CLK_PER_US = 50
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic [1:0]  kind,
  input  logic [7:0]  target,
  input  logic        bcast,
  input  logic [7:0]  vec,
  input  logic [31:0] start_addr,
  input  logic [31:0] poll_data,
  output logic        cmd_wr,
  output logic        cmd_hi,
  output logic [31:0] cmd_data,
  output logic        poll_rd,
  output logic        busy,
  output logic        done,
  output logic        err
);
  localparam int GAP_A = 10 * CLK_PER_US;
  localparam int GAP_B = 200 * CLK_PER_US;
  localparam int TW    = $clog2(GAP_B + 1);

  typedef enum logic [2:0] {S_IDLE, S_HI, S_LO, S_POLL, S_WAIT} st_t;

  st_t         st;
  logic [1:0]  kind_q, step;
  logic [7:0]  tgt_q, vec_q, page_q;
  logic        bc_q, done_q, err_q;
  logic [TW-1:0] cnt;
  logic [2:0]  mode;
  logic [7:0]  vsel;
  logic [31:0] lo_word, hi_word;

  wire addr_ok = (start_addr[31:20] == 12'd0) && (start_addr[11:0] == 12'd0);
  wire last    = (kind_q != 2'd3) || (step == 2'd2);

  always_comb begin
    mode = 3'd0;
    vsel = 8'd0;
    case (kind_q)
      2'd0: begin mode = 3'd0; vsel = vec_q; end
      2'd1: mode = 3'd2;
      2'd2: mode = 3'd5;
      default: begin
        mode = (step == 2'd0) ? 3'd5 : 3'd6;
        vsel = (step == 2'd0) ? 8'd0 : page_q;
      end
    endcase
  end

  assign lo_word  = {12'd0, bc_q ? 2'b11 : 2'b00, 2'b00, 4'b0100, 1'b0, mode, vsel};
  assign hi_word  = bc_q ? 32'd0 : {tgt_q, 24'd0};
  assign cmd_wr   = (st == S_HI) || (st == S_LO);
  assign cmd_hi   = (st == S_HI);
  assign cmd_data = (st == S_HI) ? hi_word : (st == S_LO) ? lo_word : 32'd0;
  assign poll_rd  = (st == S_POLL);
  assign busy     = (st != S_IDLE);
  assign done     = done_q;
  assign err      = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; kind_q <= 2'd0; step <= 2'd0; tgt_q <= 8'd0; vec_q <= 8'd0;
      page_q <= 8'd0; bc_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0; cnt <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (req) begin
          if (kind == 2'd3 && !addr_ok) begin
            err_q <= 1'b1;
          end else begin
            err_q  <= 1'b0;
            kind_q <= kind;
            tgt_q  <= target;
            bc_q   <= bcast;
            vec_q  <= vec;
            page_q <= start_addr[19:12];
            step   <= 2'd0;
            st     <= S_HI;
          end
        end
        S_HI: st <= S_LO;
        S_LO: st <= S_POLL;
        S_POLL: if (!poll_data[12]) begin
          if (last) begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            cnt <= (step == 2'd0) ? TW'(GAP_A - 1) : TW'(GAP_B - 1);
            st  <= S_WAIT;
          end
        end
        S_WAIT: if (cnt == '0) begin
          step <= step + 2'd1;
          st   <= S_HI;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r2_hi_before_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_hi) |=> (cmd_wr && !cmd_hi));
  a_r3_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_rd && poll_data[12]) |=> (poll_rd && !cmd_wr));
  a_r8_no_send_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !cmd_wr);
  a_r9_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(tgt_q) && $stable(kind_q) && $stable(bc_q)));
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r6_step_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (step <= 2'd2));
endmodule

// File: tb/ipi_seq_test.sv
module ipi_seq_test;
  localparam int CPU = 2;
  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, bcast = 1'b0;
  logic [1:0] kind = 2'd0;
  logic [7:0] target = 8'd0, vec = 8'd0;
  logic [31:0] start_addr = 32'd0, poll_data;
  logic cmd_wr, cmd_hi, poll_rd, busy, done, err;
  logic [31:0] cmd_data;

  int checks = 0, fails = 0, cyc = 0, acc = 0, left = 0;
  int wr_n = 0, npoll = 0;
  logic [31:0] wr_data [16];
  logic        wr_hi   [16];
  int          wr_cyc  [16];

  ipi_seq #(.CLK_PER_US(CPU)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .kind(kind), .target(target), .bcast(bcast),
    .vec(vec), .start_addr(start_addr), .poll_data(poll_data), .cmd_wr(cmd_wr),
    .cmd_hi(cmd_hi), .cmd_data(cmd_data), .poll_rd(poll_rd), .busy(busy), .done(done), .err(err));

  always #10 clk = ~clk;

  assign poll_data = (left != 0) ? (32'hA5A5A5A5 | 32'h1000) : (32'hA5A5A5A5 & ~32'h1000);

  always @(posedge clk) begin
    if (cmd_wr && !cmd_hi) left <= acc;
    else if (poll_rd && left != 0) left <= left - 1;
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (cmd_wr && wr_n < 16) begin
      wr_data[wr_n] <= cmd_data; wr_hi[wr_n] <= cmd_hi; wr_cyc[wr_n] <= cyc; wr_n <= wr_n + 1;
    end
    if (poll_rd) npoll <= npoll + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic start(input [1:0] k, input [7:0] t, input b, input [7:0] v, input [31:0] a);
    @(negedge clk);
    kind = k; target = t; bcast = b; vec = v; start_addr = a; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_end();
    int to = 0;
    while (!done && !err && to < 3000) begin @(negedge clk); to++; end
    if (to >= 3000) chk("R10 timeout", 0, 1);
    chk("R10 busy low at done", busy, 0);
    @(negedge clk);
    chk("R10 done one cycle", done, 0);
  endtask

  function automatic logic [31:0] lo_exp(input [2:0] m, input [7:0] v, input b);
    return (32'd1 << 14) | (b ? (32'd3 << 18) : 32'd0) | (32'(m) << 8) | 32'(v);
  endfunction

  task automatic verify(input [1:0] k, input [7:0] t, input b, input [7:0] v, input [31:0] a);
    int n = (k == 2'd3) ? 3 : 1;
    logic [31:0] hi = b ? 32'd0 : {t, 24'd0};
    chk("R2 write count", wr_n, 2 * n);
    chk("R3 poll count", npoll, n * (acc + 1));
    for (int i = 0; i < n; i++) begin
      logic [2:0] m; logic [7:0] vv;
      case (k)
        2'd0: begin m = 3'd0; vv = v; end
        2'd1: begin m = 3'd2; vv = 8'd0; end
        2'd2: begin m = 3'd5; vv = 8'd0; end
        default: begin m = (i == 0) ? 3'd5 : 3'd6; vv = (i == 0) ? 8'd0 : a[19:12]; end
      endcase
      chk("R2 high first", wr_hi[2*i], 1);
      chk("R2 low second", wr_hi[2*i+1], 0);
      chk("R2 consecutive", wr_cyc[2*i+1] - wr_cyc[2*i], 1);
      chk("R1 high word", wr_data[2*i], hi);
      chk((k == 2'd3) ? "R6 low word" : "R5 R4 low word", wr_data[2*i+1], lo_exp(m, vv, b));
    end
    if (k == 2'd3) begin
      chk("R7 gap after INIT", wr_cyc[3] - wr_cyc[1], 10 * CPU + acc + 3);
      chk("R7 gap after STARTUP", wr_cyc[5] - wr_cyc[3], 200 * CPU + acc + 3);
    end
  endtask

  task automatic run(input [1:0] k, input [7:0] t, input b, input [7:0] v, input [31:0] a, input int ac);
    acc = ac; wr_n = 0; npoll = 0;
    start(k, t, b, v, a);
    chk("R10 busy after accept", busy, 1);
    wait_end();
    chk("R8 err cleared", err, 0);
    verify(k, t, b, v, a);
  endtask

  task automatic run_bad(input [31:0] a);
    wr_n = 0; npoll = 0;
    start(2'd3, 8'h21, 1'b0, 8'h00, a);
    chk("R8 err set", err, 1);
    chk("R8 not busy", busy, 0);
    repeat (5) @(negedge clk);
    chk("R8 nothing sent", wr_n, 0);
    chk("R8 err held", err, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("reset busy", busy, 0);
    chk("reset done", done, 0);
    chk("reset err", err, 0);
    chk("reset cmd_wr", cmd_wr, 0);
    rst_n = 1'b1;
    for (int v = 0; v < 256; v++)
      run(2'd0, 8'(v ^ 8'h5A), v[0], 8'(v), 32'd0, v % 3);
    for (int t = 0; t < 256; t += 15) begin
      run(2'd1, 8'(t), t[1], 8'hEE, 32'd0, t % 4);
      run(2'd2, 8'(t), t[0], 8'h33, 32'd0, (t + 1) % 4);
    end
    for (int p = 0; p < 256; p += 17)
      run(2'd3, 8'(p + 3), p[0], 8'h44, 32'(p) << 12, p % 4);
    run_bad(32'h0010_0000);
    run(2'd3, 8'h01, 1'b0, 8'h00, 32'h000F_F000, 1);
    run_bad(32'h000F_F001);
    run_bad(32'h0000_0800);
    run_bad(32'hFFFF_F000);
    run(2'd0, 8'h10, 1'b1, 8'h80, 32'h0000_0123, 0);
    // R9: request mid-sequence must be ignored
    acc = 2; wr_n = 0; npoll = 0;
    start(2'd3, 8'h12, 1'b0, 8'h00, 32'h0003_4000);
    repeat (4) @(negedge clk);
    req = 1'b1; kind = 2'd0; target = 8'h77; bcast = 1'b1; vec = 8'h99;
    @(negedge clk);
    req = 1'b0;
    wait_end();
    verify(2'd3, 8'h12, 1'b0, 8'h00, 32'h0003_4000);
    repeat (5) @(negedge clk);
    chk("R9 no extra command", wr_n, 6);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule